// File: doc/BRIEF.md
# Clear-on-read interrupt status and mask register pair

This block is an interrupt status register and an interrupt mask register that share one bus address. A read strobe returns the status byte. A write strobe loads the mask byte. The status register cannot be written. Five event inputs each set a sticky status bit with a one-cycle pulse. Two live level inputs, a lock level and a remote level, are shown in the status byte as they are in that cycle.

Reading the status byte clears the sticky bits. A read is the whole span during which chip select and read are both high, and it may last several clocks. While that span is open the sticky bits stay frozen. Events that arrive during the span are collected on the side. On the clock after the span closes, the sticky bits are replaced by the collected events, so the clear takes effect and no event is lost.

A summary interrupt bit is set when any sticky bit is set and its enable is set. It is also set by a pending flag from a companion register pair, which arrives already masked. The summary bit drives the interrupt output and is returned as the top bit of the status byte. Two mask bits do not enable anything: they are plain control outputs for DMA direction.

A two-state read-window controller sequences the block.
- ST_IDLE: no read is open. Events set sticky bits directly.
- ST_READ: a read span is open. Events are deferred.

The transitions are as follows.
- T_OPEN goes from ST_IDLE to ST_READ when a read is first seen. The events of that cycle become the first deferred set.
- T_HOLD stays in ST_READ while the read continues. It collects more events.
- T_CLOSE goes from ST_READ to ST_IDLE when the read strobe has dropped. It loads the deferred set, together with any events of the closing cycle, into the sticky bits.

Top module: `irq_stat_mask_pair`

## Requirements
- R1: While reset is asserted and after its release, all sticky status bits and all mask bits are zero. The interrupt output and both DMA control outputs are therefore low.
- R2: `rdata` holds the status byte in the same cycle, with no register on the path. Its layout is: bit 7 summary interrupt, bit 6 SRQI, bit 5 lock level, bit 4 remote level, bit 3 CO, bit 2 LOKC, bit 1 REMC, bit 0 ADSC.
- R3: Each event pulse sets its sticky bit. The pulse-to-bit mapping is `ev_pulse[4]` SRQI, `ev_pulse[3]` CO, `ev_pulse[2]` LOKC, `ev_pulse[1]` REMC, `ev_pulse[0]` ADSC. When no read span is open, the bit shows on `rdata` from the next clock. The bit is set whatever the mask holds.
- R4: A read span is every consecutive cycle with `cs` and `rd` both high. Throughout the span, the sticky bits seen on `rdata` do not change.
- R5: On the clock after a read span ends, each sticky bit is cleared. A bit whose event arrived during the span, or in the first cycle after it, is set instead.
- R6: Bits 5 and 4 of `rdata` always equal `lvl_lok` and `lvl_rem` in the current cycle, and a read does not clear them.
- R7: A clock with `cs` and `wr` high and `rd` low loads the mask. The mask layout is: `wdata[6]` SRQI enable, `wdata[5]` DMA-out control, `wdata[4]` DMA-in control, `wdata[3:0]` enables for CO, LOKC, REMC and ADSC. `wdata[7]` is ignored. A write is ignored if `rd` is also high.
- R8: `irq` and `rdata[7]` are high exactly when some sticky bit and its enable are both set, or when `other_pending` is high. The DMA control bits and the level inputs never affect `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for the shared address |
| rd | input | 1 | Read strobe (status byte) |
| wr | input | 1 | Write strobe (mask byte) |
| wdata | input | 8 | Mask write data |
| ev_pulse | input | 5 | One-cycle event pulses for the five sticky bits |
| lvl_lok | input | 1 | Live lock level, shown in status bit 5 |
| lvl_rem | input | 1 | Live remote level, shown in status bit 4 |
| other_pending | input | 1 | Already-masked pending flag from the companion pair |
| rdata | output | 8 | Status byte |
| irq | output | 1 | Summary interrupt request |
| dma_out_en | output | 1 | DMA-out control bit of the mask |
| dma_in_en | output | 1 | DMA-in control bit of the mask |

## Verification
A wrong read-window state shows on `rdata` within one clock. An event that should have been deferred appears in the middle of a read. A clear that is missed leaves a stale bit after the span closes. A deferred set that is dropped loses a bit that should have survived. A corrupted mask or sticky bit changes `irq` and `rdata[7]` in the same cycle, as long as the matching enable is set. For that reason the random phase keeps enables set for much of the run, and the expected status byte is compared in every cycle.

// File: rtl/ism_pkg.sv
package ism_pkg;

    localparam int DATA_W  = 8;
    localparam int NUM_EVT = 5;

    // status byte positions
    localparam int ST_INT_B  = 7;
    localparam int ST_SRQ_B  = 6;
    localparam int ST_LOK_B  = 5;
    localparam int ST_REM_B  = 4;

    // mask byte positions
    localparam int MK_SRQ_B  = 6;
    localparam int MK_DOUT_B = 5;
    localparam int MK_DIN_B  = 4;

    // sticky vector index of the SRQI bit (others sit at 3..0)
    localparam int EV_SRQ_I  = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_READ = 1'b1
    } rd_state_e;

endpackage

// File: rtl/ism_read_fsm.sv
module ism_read_fsm
    import ism_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      win,
    output rd_state_e state,
    output logic      open_evt,
    output logic      defer_evt,
    output logic      close_evt
);

    rd_state_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        open_evt  = 1'b0;
        defer_evt = 1'b0;
        close_evt = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (win) begin
                    open_evt  = 1'b1;     // T_OPEN
                    state_nxt = ST_READ;
                end
            end
            ST_READ: begin
                if (win) begin
                    defer_evt = 1'b1;     // T_HOLD
                end else begin
                    close_evt = 1'b1;     // T_CLOSE
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/ism_sticky_bank.sv
module ism_sticky_bank #(
    parameter int NUM_EVT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               open_evt,
    input  logic               defer_evt,
    input  logic               close_evt,
    input  logic [NUM_EVT-1:0] ev,
    output logic [NUM_EVT-1:0] sticky,
    output logic [NUM_EVT-1:0] pend
);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sticky[i] <= 1'b0;
                pend[i]   <= 1'b0;
            end else if (close_evt) begin
                // clear on read, deferred sets win
                sticky[i] <= pend[i] | ev[i];
                pend[i]   <= 1'b0;
            end else if (open_evt) begin
                pend[i]   <= ev[i];
            end else if (defer_evt) begin
                pend[i]   <= pend[i] | ev[i];
            end else begin
                sticky[i] <= sticky[i] | ev[i];
            end
        end
    end

endmodule

// File: rtl/ism_mask_reg.sv
module ism_mask_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-2:0] mask_q
);

    logic unused_top_bit;
    assign unused_top_bit = wdata[DATA_W-1];

    for (genvar i = 0; i < DATA_W - 1; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[i] <= 1'b0;
            end else if (wr_en) begin
                mask_q[i] <= wdata[i];
            end
        end
    end

endmodule

// File: rtl/ism_summary.sv
module ism_summary
    import ism_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_EVT = 5
) (
    input  logic [NUM_EVT-1:0] sticky,
    input  logic [NUM_EVT-1:0] en,
    input  logic               lvl_lok,
    input  logic               lvl_rem,
    input  logic               other_pending,
    output logic               irq,
    output logic [DATA_W-1:0]  rdata
);

    localparam int LOW_EVT = NUM_EVT - 1;

    logic [NUM_EVT-1:0] hot;

    always_comb begin
        hot = sticky & en;
        irq = (|hot) | other_pending;
    end

    always_comb begin
        rdata                = '0;
        rdata[ST_INT_B]      = irq;
        rdata[ST_SRQ_B]      = sticky[EV_SRQ_I];
        rdata[ST_LOK_B]      = lvl_lok;
        rdata[ST_REM_B]      = lvl_rem;
        rdata[LOW_EVT-1:0]   = sticky[LOW_EVT-1:0];
    end

endmodule

// File: rtl/irq_stat_mask_pair.sv
module irq_stat_mask_pair
    import ism_pkg::*;
#(
    parameter int DATA_W  = ism_pkg::DATA_W,
    parameter int NUM_EVT = ism_pkg::NUM_EVT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               rd,
    input  logic               wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_EVT-1:0] ev_pulse,
    input  logic               lvl_lok,
    input  logic               lvl_rem,
    input  logic               other_pending,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq,
    output logic               dma_out_en,
    output logic               dma_in_en
);

    localparam int LOW_EVT = NUM_EVT - 1;

    logic               win;
    logic               wr_en;
    rd_state_e          rd_state;
    logic               open_evt;
    logic               defer_evt;
    logic               close_evt;
    logic [NUM_EVT-1:0] sticky_q;
    logic [NUM_EVT-1:0] pend_q;
    logic [DATA_W-2:0]  mask_q;
    logic [NUM_EVT-1:0] en_vec;

    assign win   = cs & rd;
    assign wr_en = cs & wr & ~rd;

    ism_read_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .win       (win),
        .state     (rd_state),
        .open_evt  (open_evt),
        .defer_evt (defer_evt),
        .close_evt (close_evt)
    );

    ism_sticky_bank #(.NUM_EVT(NUM_EVT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_evt  (open_evt),
        .defer_evt (defer_evt),
        .close_evt (close_evt),
        .ev        (ev_pulse),
        .sticky    (sticky_q),
        .pend      (pend_q)
    );

    ism_mask_reg #(.DATA_W(DATA_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wdata  (wdata),
        .mask_q (mask_q)
    );

    assign en_vec     = {mask_q[MK_SRQ_B], mask_q[LOW_EVT-1:0]};
    assign dma_out_en = mask_q[MK_DOUT_B];
    assign dma_in_en  = mask_q[MK_DIN_B];

    ism_summary #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) u_sum (
        .sticky        (sticky_q),
        .en            (en_vec),
        .lvl_lok       (lvl_lok),
        .lvl_rem       (lvl_rem),
        .other_pending (other_pending),
        .irq           (irq),
        .rdata         (rdata)
    );

endmodule

// File: rtl/ism_checker.sv
module ism_checker
    import ism_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs,
    input logic       rd,
    input logic       wr,
    input logic [7:0] wdata,
    input logic [4:0] ev_pulse,
    input logic       other_pending,
    input logic       irq,
    input logic       dma_out_en,
    input logic       dma_in_en,
    input logic [4:0] sticky,
    input logic [4:0] pend,
    input rd_state_e  state
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (sticky == 5'd0 && !dma_out_en && !dma_in_en));

    // R3
    idle_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(cs && rd)) |=> ((sticky & $past(ev_pulse)) == $past(ev_pulse)));

    // R4
    window_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && $past(cs && rd)) |-> $stable(sticky));

    // R5
    close_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && !(cs && rd) && pend == 5'd0 && ev_pulse == 5'd0) |=> (sticky == 5'd0));

    // R7
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !rd) |=> (dma_out_en == $past(wdata[5]) && dma_in_en == $past(wdata[4])));

    // R7
    read_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && rd) |=> $stable({dma_out_en, dma_in_en}));

    // R8
    companion_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        other_pending |-> irq);

endmodule

bind irq_stat_mask_pair ism_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs            (cs),
    .rd            (rd),
    .wr            (wr),
    .wdata         (wdata),
    .ev_pulse      (ev_pulse),
    .other_pending (other_pending),
    .irq           (irq),
    .dma_out_en    (dma_out_en),
    .dma_in_en     (dma_in_en),
    .sticky        (sticky_q),
    .pend          (pend_q),
    .state         (rd_state)
);

// File: tb/irq_stat_mask_pair_test.sv
module irq_stat_mask_pair_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [4:0] ev_pulse = 5'd0;
    logic       lvl_lok = 1'b0, lvl_rem = 1'b0, other_pending = 1'b0;
    logic [7:0] rdata;
    logic       irq, dma_out_en, dma_in_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [4:0] m_st   = 5'd0;
    logic [4:0] m_pend = 5'd0;
    logic       m_read = 1'b0;
    logic [6:0] m_mask = 7'd0;

    irq_stat_mask_pair uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .wdata(wdata),
        .ev_pulse(ev_pulse), .lvl_lok(lvl_lok), .lvl_rem(lvl_rem),
        .other_pending(other_pending), .rdata(rdata), .irq(irq),
        .dma_out_en(dma_out_en), .dma_in_en(dma_in_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_irq();
        return (|(m_st & {m_mask[6], m_mask[3:0]})) | other_pending;
    endfunction

    function automatic logic [7:0] exp_rdata();
        return {exp_irq(), m_st[4], lvl_lok, lvl_rem, m_st[3:0]};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2 R3 R5 sticky bits", {3'd0, rdata[6], rdata[3:0]}, {3'd0, m_st});
        check("R6 live levels", {6'd0, rdata[5:4]}, {6'd0, lvl_lok, lvl_rem});
        check("R8 irq", {7'd0, irq}, {7'd0, exp_irq()});
        check("R2 status bit 7", {7'd0, rdata[7]}, {7'd0, exp_irq()});
        check("R7 dma controls", {6'd0, dma_out_en, dma_in_en}, {6'd0, m_mask[5:4]});
    endtask

    task automatic model_edge();
        logic w;
        w = cs & rd;
        if (!m_read) begin
            if (w) begin m_pend = ev_pulse; m_read = 1'b1; end
            else m_st = m_st | ev_pulse;
        end else begin
            if (w) m_pend = m_pend | ev_pulse;
            else begin m_st = m_pend | ev_pulse; m_pend = 5'd0; m_read = 1'b0; end
        end
        if (cs && wr && !rd) m_mask = wdata[6:0];
    endtask

    // inputs are set at the falling edge before calling
    task automatic cycle();
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_in();
        cs = 0; rd = 0; wr = 0; ev_pulse = 5'd0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        @(negedge clk);
        #1;
        // R1 reset state
        check("R1 reset status", rdata, 8'h00);
        check("R1 reset outputs", {5'd0, irq, dma_out_en, dma_in_en}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        cycle();

        // R3 event sets bit with mask clear
        ev_pulse = 5'b10000; cycle();
        idle_in(); #1;
        check("R3 SRQI set with mask clear", rdata, 8'h40);
        cycle();

        // R8 enable SRQI
        cs = 1; wr = 1; wdata = 8'h40; cycle();
        idle_in(); #1;
        check("R8 enabled SRQI raises irq", {7'd0, irq}, 8'h01);
        cycle();

        // R4 R5 read span with CO arriving mid-span
        cs = 1; rd = 1; cycle();
        ev_pulse = 5'b01000; cycle();
        ev_pulse = 5'd0; #1;
        check("R4 frozen during span", rdata, 8'hC0);
        cycle();
        idle_in(); #1;
        check("R4 frozen in closing cycle", rdata, 8'hC0);
        cycle();
        #1;
        check("R5 clear keeps deferred CO", rdata, 8'h08);
        cycle();

        // R7 write with rd high ignored, bit 7 ignored
        cs = 1; rd = 1; wr = 1; wdata = 8'h38; cycle();
        idle_in(); cycle();
        #1;
        check("R7 write during read ignored", {6'd0, dma_out_en, dma_in_en}, 8'h00);
        check("R5 plain read clears CO", rdata, 8'h00);
        cs = 1; wr = 1; wdata = 8'hB0; cycle();
        idle_in(); #1;
        check("R7 dma loaded bit7 dropped", {6'd0, dma_out_en, dma_in_en}, 8'h03);
        check("R8 dma bits do not raise irq", {7'd0, irq}, 8'h00);
        cycle();

        // R6 levels survive a read
        lvl_lok = 1; lvl_rem = 1; cs = 1; rd = 1; cycle();
        idle_in(); cycle();
        #1;
        check("R6 levels not cleared", rdata, 8'h30);
        check("R8 levels not irq sources", {7'd0, irq}, 8'h00);
        lvl_lok = 0; lvl_rem = 0;

        // R8 companion pending
        other_pending = 1; #1;
        check("R8 companion flag alone", {7'd0, irq}, 8'h01);
        cycle();
        other_pending = 0;

        // R5 event in first cycle after span wins
        cs = 1; rd = 1; cycle();
        idle_in(); ev_pulse = 5'b00001; cycle();
        idle_in(); #1;
        check("R5 closing-cycle event kept", {3'd0, rdata[6], rdata[3:0]}, 8'h01);
        cycle();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (m_read || (cs && rd)) begin
                rd = (r < 65); cs = rd ? 1'b1 : ($urandom_range(0, 1) == 1);
            end else begin
                cs = (r < 40); rd = cs && (r < 20);
            end
            wr = cs && ($urandom_range(0, 3) == 0);
            wdata = 8'($urandom);
            if ($urandom_range(0, 2) != 0) wdata[6] = 1'b1;
            wdata[3:0] = wdata[3:0] | 4'($urandom_range(0, 15));
            ev_pulse = ($urandom_range(0, 2) == 0) ? 5'($urandom) : 5'd0;
            lvl_lok = ($urandom_range(0, 1) == 1);
            lvl_rem = ($urandom_range(0, 1) == 1);
            other_pending = ($urandom_range(0, 9) == 0);
            cycle();
        end

        finish_run();
    end

endmodule